// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block holds one core's inter-processor interrupt state. It has a 32-bit pending vector, a 32-bit enable register, a write-only clear port, a write-only set port that the local side may not use, and a 32-byte mailbox made of four 64-bit buffers. A single memory-mapped request port reaches all of these with 1-, 2-, 4- or 8-byte accesses. Every request gets a response one cycle later, with read data or an error flag.

Two side inputs serve the remote senders. A set-bits strobe ORs interrupt vectors into the pending vector. A mailbox word strobe writes selected bytes of one 32-bit mailbox word. The interrupt output to the core stays high for as long as any pending bit is set.

The block does not decode send commands. It does not carry traffic between cores.

Top module: `ipi_regblock`

## Requirements
- R1: A synchronous reset clears the pending vector, the enable register and all mailbox bytes. During reset and in the cycle after it, `rsp_valid` and `irq_out` are low.
- R2: A request accepted at a clock edge (`req_valid` high) produces exactly one response in the following cycle (`rsp_valid` high). `rsp_valid` is low in any cycle that follows a cycle with no request.
- R3: Only `req_addr[8:0]` selects a register. The map is: pending vector at 0x00, enable at 0x04, set at 0x08, clear at 0x0C, mailbox at 0x20 to 0x3F. Any other offset gives `rsp_err`=1 with `rsp_rdata`=0 and changes no state. Every errored response carries zero data.
- R4: A write to 0x04 loads `req_wdata[31:0]` into the enable register. A read of 0x00 or 0x04 returns the register, zero-extended and cut to the access size.
- R5: A read of 0x08 or 0x0C returns zero without an error.
- R6: A local write to 0x00 or 0x08 returns an error and leaves the pending vector unchanged.
- R7: A write to 0x0C clears every pending bit that is 1 in `req_wdata[31:0]`.
- R8: `remote_set_valid` ORs `remote_set_bits` into the pending vector. When a remote set and a local clear reach the same bit in one cycle, that bit ends up set.
- R9: `irq_out` is high exactly while the pending vector is nonzero. It follows the pending vector from the cycle after the edge that changed it, and it falls only after a clear write.
- R10: `req_size` encodes the access length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. Mailbox accesses use little-endian byte order: byte k of the data sits at offset+k. Reads are zero-extended, and unaligned accesses are allowed.
- R11: A mailbox access with offset+length greater than 0x40 returns an error and writes nothing.
- R12: `remote_mbox_valid` writes byte b of `remote_mbox_data` to offset 0x20+4*`remote_mbox_idx`+b for each set bit b of `remote_mbox_bmask`. A remote write overrides a local write to the same byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 9 bits decoded |
| req_size | input | 2 | Access length code |
| req_wdata | input | 64 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| remote_set_valid | input | 1 | Remote vector post strobe |
| remote_set_bits | input | VEC_W | Vectors to post |
| remote_mbox_valid | input | 1 | Remote mailbox word write strobe |
| remote_mbox_idx | input | 3 | Mailbox word index |
| remote_mbox_bmask | input | 4 | Byte enables within the word |
| remote_mbox_data | input | 32 | Mailbox word data |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
Two pairs of functions can fall in the same cycle. A remote vector post can coincide with a local clear write, and a remote mailbox word write can coincide with a local mailbox write to overlapping bytes. The bench drives each pair in one cycle: first on the same pending bit or mailbox byte, then on neighbouring ones. The behavioural model applies the local action first and the remote one second. After the edge, the bench judges `irq_out` and a read-back of the pending vector or mailbox bytes against that model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int BUS_W   = 64;
    localparam int LANES   = BUS_W / 8;
    localparam int OFF_W   = 9;

    localparam logic [OFF_W-1:0] OFF_PEND  = 9'h000;
    localparam logic [OFF_W-1:0] OFF_ENAB  = 9'h004;
    localparam logic [OFF_W-1:0] OFF_POST  = 9'h008;
    localparam logic [OFF_W-1:0] OFF_CLR   = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_MBOX  = 9'h020;

    typedef enum logic [2:0] {
        TGT_PEND,
        TGT_ENAB,
        TGT_POST,
        TGT_CLR,
        TGT_MBOX,
        TGT_NONE
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic       err;
        logic [3:0] len;
    } dec_t;

    function automatic logic [3:0] size_len(input logic [1:0] sz);
        return 4'(1 << sz);
    endfunction

    function automatic logic [BUS_W-1:0] size_mask(input logic [1:0] sz);
        logic [BUS_W-1:0] m;
        case (sz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MBOX_BYTES = 32,
    localparam int MB_OFF_W  = $clog2(MBOX_BYTES)
) (
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    output dec_t                dec,
    output logic [MB_OFF_W-1:0] mb_off
);

    localparam logic [OFF_W:0] MB_END = (OFF_W+1)'(32 + MBOX_BYTES);

    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   end_pos;
    logic             in_mbox;
    logic             unused_hi;

    assign off       = req_addr[OFF_W-1:0];
    assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];
    assign end_pos   = {1'b0, off} + (OFF_W+1)'(size_len(req_size));
    assign in_mbox   = (off >= OFF_MBOX) && ({1'b0, off} < MB_END);
    assign mb_off    = MB_OFF_W'(off - OFF_MBOX);

    always_comb begin
        dec.len = size_len(req_size);
        dec.err = 1'b0;
        if (off == OFF_PEND) begin
            dec.tgt = TGT_PEND;
            dec.err = req_write;
        end else if (off == OFF_ENAB) begin
            dec.tgt = TGT_ENAB;
        end else if (off == OFF_POST) begin
            dec.tgt = TGT_POST;
            dec.err = req_write;
        end else if (off == OFF_CLR) begin
            dec.tgt = TGT_CLR;
        end else if (in_mbox) begin
            dec.tgt = TGT_MBOX;
            dec.err = (end_pos > MB_END);
        end else begin
            dec.tgt = TGT_NONE;
            dec.err = 1'b1;
        end
    end

endmodule

// File: rtl/ipi_status.sv
module ipi_status #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_bits,
    input  logic             post_en,
    input  logic [VEC_W-1:0] post_bits,
    input  logic             enab_we,
    input  logic [VEC_W-1:0] enab_wdata,
    output logic [VEC_W-1:0] pend_q,
    output logic [VEC_W-1:0] enab_q,
    output logic             irq_q
);

    logic [VEC_W-1:0] clr_mask;
    logic [VEC_W-1:0] post_mask;
    logic [VEC_W-1:0] pend_d;

    assign clr_mask  = clr_en  ? clr_bits  : '0;
    assign post_mask = post_en ? post_bits : '0;
    // posting applied after clearing, so a collision leaves the bit set
    assign pend_d    = (pend_q & ~clr_mask) | post_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            enab_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_d;
            if (enab_we) enab_q <= enab_wdata;
        end
    end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int MBOX_BYTES  = 32,
    localparam int MB_OFF_W   = $clog2(MBOX_BYTES),
    localparam int WORDS      = MBOX_BYTES / 4,
    localparam int WIDX_W     = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                loc_we,
    input  logic [MB_OFF_W-1:0] loc_off,
    input  logic [3:0]          loc_len,
    input  logic [BUS_W-1:0]    loc_wdata,
    input  logic                rem_we,
    input  logic [WIDX_W-1:0]   rem_idx,
    input  logic [3:0]          rem_bmask,
    input  logic [31:0]         rem_wdata,
    output logic [BUS_W-1:0]    rd_data
);

    logic [8*MBOX_BYTES-1:0] store;

    for (genvar gb = 0; gb < MBOX_BYTES; gb++) begin : g_byte
        logic             rem_hit;
        logic             loc_hit;
        logic [BUS_W-1:0] shifted;
        logic [7:0]       byte_q;

        always_comb begin
            rem_hit = rem_we && rem_bmask[gb % 4]
                      && (rem_idx == WIDX_W'(gb / 4));
            loc_hit = loc_we && (int'(loc_off) <= gb)
                      && (gb < int'(loc_off) + int'(loc_len));
            shifted = loc_wdata >> (8 * (gb - int'(loc_off)));
        end

        always_ff @(posedge clk) begin
            if (rst)          byte_q <= '0;
            else if (rem_hit) byte_q <= rem_wdata[8*(gb%4) +: 8];
            else if (loc_hit) byte_q <= shifted[7:0];
        end

        assign store[8*gb +: 8] = byte_q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(loc_len) && int'(loc_off) + k < MBOX_BYTES)
                rd_data[8*k +: 8] = store[8*(int'(loc_off) + k) +: 8];
        end
    end

endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
    import ipi_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VEC_W      = 32,
    parameter int MBOX_BYTES = 32,
    localparam int MB_OFF_W  = $clog2(MBOX_BYTES),
    localparam int WIDX_W    = $clog2(MBOX_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic              remote_set_valid,
    input  logic [VEC_W-1:0]  remote_set_bits,
    input  logic              remote_mbox_valid,
    input  logic [WIDX_W-1:0] remote_mbox_idx,
    input  logic [3:0]        remote_mbox_bmask,
    input  logic [31:0]       remote_mbox_data,
    output logic              irq_out
);

    dec_t                dec;
    logic [MB_OFF_W-1:0] mb_off;
    logic                act;
    logic                act_wr;
    logic [VEC_W-1:0]    pend;
    logic [VEC_W-1:0]    enab;
    logic [BUS_W-1:0]    mb_rdata;
    logic [BUS_W-1:0]    rd_mux;

    ipi_decode #(
        .ADDR_W     (ADDR_W),
        .MBOX_BYTES (MBOX_BYTES)
    ) u_dec (
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .dec       (dec),
        .mb_off    (mb_off)
    );

    assign act    = req_valid && !dec.err;
    assign act_wr = act && req_write;

    ipi_status #(
        .VEC_W (VEC_W)
    ) u_stat (
        .clk        (clk),
        .rst        (rst),
        .clr_en     (act_wr && dec.tgt == TGT_CLR),
        .clr_bits   (req_wdata[VEC_W-1:0]),
        .post_en    (remote_set_valid),
        .post_bits  (remote_set_bits),
        .enab_we    (act_wr && dec.tgt == TGT_ENAB),
        .enab_wdata (req_wdata[VEC_W-1:0]),
        .pend_q     (pend),
        .enab_q     (enab),
        .irq_q      (irq_out)
    );

    ipi_mailbox #(
        .MBOX_BYTES (MBOX_BYTES)
    ) u_mbox (
        .clk       (clk),
        .rst       (rst),
        .loc_we    (act_wr && dec.tgt == TGT_MBOX),
        .loc_off   (mb_off),
        .loc_len   (dec.len),
        .loc_wdata (req_wdata),
        .rem_we    (remote_mbox_valid),
        .rem_idx   (remote_mbox_idx),
        .rem_bmask (remote_mbox_bmask),
        .rem_wdata (remote_mbox_data),
        .rd_data   (mb_rdata)
    );

    always_comb begin
        case (dec.tgt)
            TGT_PEND: rd_mux = BUS_W'(pend) & size_mask(req_size);
            TGT_ENAB: rd_mux = BUS_W'(enab) & size_mask(req_size);
            TGT_MBOX: rd_mux = mb_rdata;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (act && !req_write) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/ipi_regblock_chk.sv
module ipi_regblock_chk
    import ipi_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VEC_W      = 32,
    parameter int MBOX_BYTES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              remote_set_valid,
    input logic [VEC_W-1:0]  remote_set_bits,
    input logic              irq_out
);

    localparam logic [OFF_W:0] MB_END = (OFF_W+1)'(32 + MBOX_BYTES);

    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   end_pos;
    logic             mb_oob;

    assign off     = req_addr[OFF_W-1:0];
    assign end_pos = {1'b0, off} + (OFF_W+1)'(size_len(req_size));
    assign mb_oob  = (off >= OFF_MBOX) && ({1'b0, off} < MB_END) && (end_pos > MB_END);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 64'd0));

    p_ctl_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (off == OFF_POST || off == OFF_CLR))
        |=> (rsp_valid && !rsp_err && rsp_rdata == 64'd0));

    p_direct_write_err_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && (off == OFF_PEND || off == OFF_POST))
        |=> rsp_err);

    p_post_raises_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (remote_set_valid && remote_set_bits != '0) |=> irq_out);

    p_irq_falls_on_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> $past(req_valid && req_write && off == OFF_CLR));

    p_bounds_err_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mb_oob) |=> rsp_err);

endmodule

bind ipi_regblock ipi_regblock_chk #(
    .ADDR_W     (ADDR_W),
    .VEC_W      (VEC_W),
    .MBOX_BYTES (MBOX_BYTES)
) u_chk (.*);

// File: tb/tb_ipi_regblock.sv
module tb_ipi_regblock;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic        remote_set_valid = 1'b0;
    logic [31:0] remote_set_bits = '0;
    logic        remote_mbox_valid = 1'b0;
    logic [2:0]  remote_mbox_idx = '0;
    logic [3:0]  remote_mbox_bmask = '0;
    logic [31:0] remote_mbox_data = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pend;
    logic [31:0] m_enab;
    logic [7:0]  m_mb [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_regblock dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // inputs are applied at a falling edge; model evaluates, edge, compare
    task automatic step(input string tag);
        int          off;
        int          len;
        bit          err;
        bit          ctl_rd;
        logic [63:0] rd;
        logic [63:0] exp_d;
        bit          exp_v;
        exp_v  = req_valid;
        err    = 0;
        ctl_rd = 0;
        rd     = '0;
        off    = int'(req_addr[8:0]);
        len    = 1 << req_size;
        if (req_valid) begin
            if (off == 0) begin
                if (req_write) err = 1; else begin rd = 64'(m_pend); ctl_rd = 1; end
            end else if (off == 4) begin
                if (req_write) m_enab = req_wdata[31:0];
                else begin rd = 64'(m_enab); ctl_rd = 1; end
            end else if (off == 8) begin
                if (req_write) err = 1;
            end else if (off == 12) begin
                if (req_write) m_pend = m_pend & ~req_wdata[31:0];
            end else if (off >= 32 && off < 64) begin
                if (off + len > 64) err = 1;
                else begin
                    for (int k = 0; k < len; k++) begin
                        if (req_write) m_mb[off-32+k] = req_wdata[8*k +: 8];
                        else rd[8*k +: 8] = m_mb[off-32+k];
                    end
                end
            end else begin
                err = 1;
            end
            if (ctl_rd && len < 8) rd = rd & ((64'd1 << (8*len)) - 64'd1);
        end
        if (remote_set_valid) m_pend = m_pend | remote_set_bits;
        if (remote_mbox_valid)
            for (int b = 0; b < 4; b++)
                if (remote_mbox_bmask[b])
                    m_mb[4*remote_mbox_idx + b] = remote_mbox_data[8*b +: 8];
        exp_d = (req_valid && !req_write && !err) ? rd : 64'd0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == exp_v, tag, "rsp_valid", 64'(rsp_valid), 64'(exp_v));
        if (exp_v) begin
            chk(rsp_err == err, tag, "rsp_err", 64'(rsp_err), 64'(err));
            chk(rsp_rdata == exp_d, tag, "rsp_rdata", rsp_rdata, exp_d);
        end
        chk(irq_out == (m_pend != 0), "R9", "irq_out", 64'(irq_out), 64'(m_pend != 0));
        req_valid         = 1'b0;
        remote_set_valid  = 1'b0;
        remote_mbox_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] sz,
                      input logic [63:0] d, input string tag);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        step(tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] sz, input string tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        req_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        step(tag);
    endtask

    task automatic post(input logic [31:0] bits);
        remote_set_valid = 1'b1; remote_set_bits = bits;
    endtask

    task automatic rmb(input logic [2:0] idx, input logic [3:0] m, input logic [31:0] d);
        remote_mbox_valid = 1'b1; remote_mbox_idx = idx;
        remote_mbox_bmask = m; remote_mbox_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        m_pend = '0;
        m_enab = '0;
        for (int i = 0; i < 32; i++) m_mb[i] = '0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 0);
        chk(irq_out == 1'b0, "R1", "irq in reset", 64'(irq_out), 0);
        rst = 1'b0;
        step("R1");
        rd(16'h0000, 2'd2, "R1");
        rd(16'h0004, 2'd2, "R1");
        for (int a = 32; a < 64; a += 8) rd(16'(a), 2'd3, "R1");
        step("R2");
        step("R2");

        wr(16'h0004, 2'd2, 64'hFFFF_0000_A5A5_1234, "R4");
        rd(16'h0004, 2'd2, "R4");
        rd(16'h0004, 2'd0, "R4");
        rd(16'h0004, 2'd1, "R4");
        rd(16'h0004, 2'd3, "R4");
        rd(16'hFE04, 2'd2, "R3");
        rd(16'h0008, 2'd2, "R5");
        rd(16'h000C, 2'd3, "R5");

        post(32'h0000_0011); step("R8");
        rd(16'h0000, 2'd2, "R8");
        wr(16'h000C, 2'd2, 64'h1, "R7");
        rd(16'h0000, 2'd2, "R7");
        wr(16'h000C, 2'd2, 64'h10, "R7");
        rd(16'h0000, 2'd2, "R7");
        post(32'h4); wr(16'h000C, 2'd2, 64'h4, "R8");
        rd(16'h0000, 2'd2, "R8");
        post(32'h8); wr(16'h000C, 2'd2, 64'hC, "R8");
        rd(16'h0000, 2'd2, "R8");
        wr(16'h0000, 2'd2, 64'hFFFF, "R6");
        wr(16'h0008, 2'd2, 64'hFFFF, "R6");
        rd(16'h0000, 2'd2, "R6");
        wr(16'h000C, 2'd2, 64'hFFFF_FFFF, "R9");

        rd(16'h0010, 2'd2, "R3");
        rd(16'h0001, 2'd0, "R3");
        wr(16'h0040, 2'd2, 64'h55, "R3");
        wr(16'h01F0, 2'd3, 64'h55, "R3");
        rd(16'h0040, 2'd0, "R3");

        wr(16'h0020, 2'd3, 64'h0123_4567_89AB_CDEF, "R10");
        rd(16'h0021, 2'd0, "R10");
        rd(16'h0026, 2'd1, "R10");
        rd(16'h0022, 2'd2, "R10");
        wr(16'h003A, 2'd2, 64'hFFFF_FFFF_1122_3344, "R10");
        rd(16'h0038, 2'd3, "R10");
        wr(16'h0025, 2'd1, 64'h0000_0000_0000_BEEF, "R10");
        rd(16'h0020, 2'd3, "R10");

        wr(16'h003C, 2'd3, 64'hAAAA_AAAA_AAAA_AAAA, "R11");
        rd(16'h003C, 2'd2, "R11");
        wr(16'h003F, 2'd1, 64'hBBBB, "R11");
        rd(16'h003F, 2'd0, "R11");
        rd(16'h003E, 2'd2, "R11");
        wr(16'h003F, 2'd0, 64'h77, "R11");
        rd(16'h003F, 2'd0, "R11");

        rmb(3'd7, 4'b0101, 32'hC0DE_F00D); step("R12");
        rd(16'h003C, 2'd2, "R12");
        rmb(3'd2, 4'b0011, 32'h1111_2222);
        wr(16'h0028, 2'd3, 64'h9999_8888_7777_6666, "R12");
        rd(16'h0028, 2'd3, "R12");

        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) post($urandom & 32'h0000_0F0F);
            if ($urandom_range(0, 4) == 0)
                rmb(3'($urandom_range(0, 7)), 4'($urandom), $urandom);
            if (op < 7) begin
                logic [15:0] a;
                a = 16'($urandom_range(0, 72));
                if ($urandom_range(0, 3) == 0) a[15:9] = 7'($urandom);
                if (op < 3) wr(a, 2'($urandom), {$urandom, $urandom}, "R10");
                else rd(a, 2'($urandom), "R10");
            end else if (op == 7) begin
                wr(16'h000C, 2'd2, 64'($urandom), "R7");
            end else begin
                step("R2");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule